// File: doc/BRIEF.md
# ARINC 429 Receive Channel Controller

This block is the host-facing side of one ARINC 429 receive channel. It takes 32-bit words that have already been deserialized, each marked by a one-cycle valid strobe. Each word passes an acceptance filter made of three checks. Words that pass are queued in a receive FIFO. The first check looks up the label in a small label table. The second compares the two source/destination identifier bits against programmed values. The third treats the last bit as parity with a selectable sense. A control bit enables or disables each check on its own.

A host reaches the channel through four registers, selected by CPU address bits 3:2. These are the data register, the control register, the status register and the label table port. The host sets the filter options and loads the label table. It polls FIFO empty, level and full, and pops words by reading the data register. A data-rate select bit in the control register is passed to the line receiver on an output pin and has no effect inside the block.

Top module: `a429_rx_chan`

ARINC bit n of a word is `word_i[n-1]`: the label is `word_i[7:0]`, the identifier bits 9 and 10 are `word_i[8]` and `word_i[9]`, and bit 32 is `word_i[31]`.

## Requirements
- R1: `reg_idx_i` (CPU address bits 3:2) selects the register: 0 data, 1 control, 2 status, 3 label table. Control bits 6:0 read back as written, control bit 7 reads 0, and the whole control register is 0 after reset.
- R2: Control bit 0 (rate select, 0 = high speed, 1 = low speed) appears on `rate_sel_o` from the cycle after the write.
- R3: With control bit 1 set, a word is accepted only if `word_i[7:0]` equals a table entry written since the last table clear. With bit 1 clear, the label is not checked.
- R4: With control bit 2 clear, bit 32 is ordinary data and parity is never checked. With bit 2 set, the parity check applies.
- R5: With the parity check on, control bit 3 = 0 requires an odd number of ones over all 32 bits and bit 3 = 1 requires an even number. A failing word is discarded.
- R6: With control bit 4 set, a word is rejected unless `word_i[8]` equals control bit 5 and `word_i[9]` equals control bit 6. With bit 4 clear, those bits are not checked.
- R7: Writing control with bit 7 = 1 returns both table pointers to entry 0 and invalidates every table entry.
- R8: Status reads return bit 0 = FIFO empty, bit 1 = at least LEVEL words stored, bit 2 = FIFO full, and other bits 0. Writes to status and data have no effect.
- R9: The FIFO holds DEPTH (32) words. A word accepted while the FIFO is full is dropped, and the stored words are unchanged.
- R10: A data read returns the oldest stored word and removes it. A data read while the FIFO is empty returns 0 and changes nothing.
- R11: Each label-port write stores `wdata_i` at the next table entry. Successive label-port reads return the entries in write order through a separate read pointer.
- R12: `rdata_o` is registered. It takes the selected value at the clock edge that samples `rd_i` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 32 | Deserialized ARINC word |
| word_valid_i | input | 1 | One-cycle strobe for `word_i` |
| reg_idx_i | input | 2 | Register index (CPU address bits 3:2) |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Host write data |
| rd_i | input | 1 | Host read strobe |
| rdata_o | output | 32 | Registered host read data |
| rate_sel_o | output | 1 | Line data-rate select |

## Verification
A word strobed at clock edge k is in the FIFO after edge k. A status or data read issued after that edge sees it. Read data and `rate_sel_o` change at the same edge that samples the strobe. The bench therefore drives every strobe at a falling edge, lets one rising edge pass, and samples at the following falling edge. The bench reaches the filter only through the data register: every verdict is observed by popping the FIFO. A rejected word shows up as a zero read from an empty FIFO.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  typedef enum logic [1:0] {
    IDX_DATA = 2'd0,
    IDX_CTRL = 2'd1,
    IDX_STAT = 2'd2,
    IDX_LBL  = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic sdi_b10;
    logic sdi_b9;
    logic sdi_en;
    logic par_even;
    logic par_en;
    logic lbl_en;
    logic rate;
  } ctrl_t;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LBL_W  = 8;
endpackage

// File: rtl/a429_label_mem.sv
module a429_label_mem #(
  parameter int unsigned N_LBL = 16,
  parameter int unsigned LW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [LW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          clr_i,
  output logic [LW-1:0] rdata_o,
  input  logic [LW-1:0] lbl_i,
  output logic          hit_o
);
  localparam int unsigned PW = (N_LBL > 1) ? $clog2(N_LBL) : 1;

  logic [LW-1:0] tab_q [N_LBL];
  logic [N_LBL-1:0] vld_q;
  logic [N_LBL-1:0] hit_vec;
  logic [PW-1:0] wptr_q, rptr_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(N_LBL - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      vld_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      vld_q  <= '0;
    end else begin
      if (wr_i) begin
        wptr_q         <= nxt(wptr_q);
        vld_q[wptr_q]  <= 1'b1;
      end
      if (rd_i) rptr_q <= nxt(rptr_q);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i) tab_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = vld_q[rptr_q] ? tab_q[rptr_q] : '0;

  for (genvar g = 0; g < N_LBL; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tab_q[g] == lbl_i);
  end
  assign hit_o = |hit_vec;

  // R7: table clear returns both pointers and empties the table
  p_ptr_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (wptr_q == '0) && (rptr_q == '0) && (vld_q == '0));
  // R11: a write advances the write pointer by one entry
  p_wr_adv_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> wptr_q == nxt($past(wptr_q)));
endmodule

// File: rtl/a429_rx_filter.sv
module a429_rx_filter
  import a429_rx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  ctrl_t             ctrl_i,
  input  logic              lbl_hit_i,
  output logic              accept_o
);
  logic odd_ones, par_ok, sdi_ok, lbl_ok;

  assign odd_ones = ^word_i;
  assign par_ok   = !ctrl_i.par_en || (ctrl_i.par_even ? !odd_ones : odd_ones);
  assign sdi_ok   = !ctrl_i.sdi_en ||
                    ((word_i[8] == ctrl_i.sdi_b9) && (word_i[9] == ctrl_i.sdi_b10));
  assign lbl_ok   = !ctrl_i.lbl_en || lbl_hit_i;
  assign accept_o = par_ok && sdi_ok && lbl_ok;
endmodule

// File: rtl/a429_rx_fifo.sv
module a429_rx_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LEVEL = 16,
  parameter int unsigned W     = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         level_o,
  output logic         full_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] fill_q;
  logic do_push, do_pop;

  assign empty_o = (fill_q == '0);
  assign full_o  = (fill_q == CW'(DEPTH));
  assign level_o = (fill_q >= CW'(LEVEL));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CW'(DEPTH));
  p_full_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(fill_q) && $stable(wp_q));
  p_empty_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> $stable(fill_q) && $stable(rp_q));
  p_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
endmodule

// File: rtl/a429_rx_chan.sv
module a429_rx_chan
  import a429_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned FIFO_LEVEL = 16,
  parameter int unsigned N_LABELS   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  input  logic [1:0]        reg_idx_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rate_sel_o
);
  ctrl_t ctrl_q;
  logic [WORD_W-1:0] rdata_q, head;
  logic [LBL_W-1:0] lbl_rdata;
  logic lbl_hit, accept, push;
  logic f_empty, f_level, f_full;
  logic wr_ctrl, wr_lbl, rd_lbl, rd_data, tab_clr;

  assign wr_ctrl = wr_i && (reg_idx_i == IDX_CTRL);
  assign wr_lbl  = wr_i && (reg_idx_i == IDX_LBL);
  assign rd_lbl  = rd_i && (reg_idx_i == IDX_LBL);
  assign rd_data = rd_i && (reg_idx_i == IDX_DATA);
  assign tab_clr = wr_ctrl && wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[6:0]);
  end
  assign rate_sel_o = ctrl_q.rate;

  a429_label_mem #(.N_LBL(N_LABELS), .LW(LBL_W)) u_lbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_lbl),
    .wdata_i (wdata_i),
    .rd_i    (rd_lbl),
    .clr_i   (tab_clr),
    .rdata_o (lbl_rdata),
    .lbl_i   (word_i[LBL_W-1:0]),
    .hit_o   (lbl_hit)
  );

  a429_rx_filter u_flt (
    .word_i    (word_i),
    .ctrl_i    (ctrl_q),
    .lbl_hit_i (lbl_hit),
    .accept_o  (accept)
  );

  assign push = word_valid_i && accept;

  a429_rx_fifo #(.DEPTH(FIFO_DEPTH), .LEVEL(FIFO_LEVEL), .W(WORD_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (word_i),
    .pop_i   (rd_data),
    .head_o  (head),
    .empty_o (f_empty),
    .level_o (f_level),
    .full_o  (f_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_i) begin
      unique case (reg_idx_e'(reg_idx_i))
        IDX_DATA: rdata_q <= f_empty ? '0 : head;
        IDX_CTRL: rdata_q <= WORD_W'(ctrl_q);
        IDX_STAT: rdata_q <= WORD_W'({f_full, f_level, f_empty});
        IDX_LBL:  rdata_q <= WORD_W'(lbl_rdata);
        default:  rdata_q <= '0;
      endcase
    end
  end
  assign rdata_o = rdata_q;

  // R5: a word failing the enabled parity check never reaches the FIFO
  p_par_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && ctrl_q.par_en && (ctrl_q.par_even == (^word_i)) && !rd_data && f_empty)
      |=> f_empty);
  // R6: identifier mismatch with the check enabled never reaches the FIFO
  p_sdi_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && ctrl_q.sdi_en && (word_i[9:8] != {ctrl_q.sdi_b10, ctrl_q.sdi_b9})
      && !rd_data && f_empty) |=> f_empty);
  // R12: read data only changes on a read
  p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q));
  // R2: rate output follows control write
  p_rate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> rate_sel_o == $past(wdata_i[0]));
endmodule

// File: tb/sim_a429_rx_chan.sv
module sim_a429_rx_chan;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] word = '0;
  logic wvalid = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] idx = '0;
  logic [7:0] wdata = '0;
  logic [31:0] rdata;
  logic rate;

  int n_chk = 0, n_fail = 0;

  a429_rx_chan u0 (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .word_valid_i(wvalid),
    .reg_idx_i(idx), .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
    .rdata_o(rdata), .rate_sel_o(rate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {ctrl[6:0], word[31:0], accept}
  localparam logic [39:0] VEC [NV] = '{
    {7'h00, 32'h0000_0100, 1'b1},  // R4 no filters
    {7'h02, 32'h1234_5631, 1'b1},  // R3 label in table
    {7'h02, 32'h1234_5677, 1'b0},  // R3 label absent
    {7'h04, 32'h0000_0001, 1'b1},  // R5 odd ok
    {7'h04, 32'h0000_0003, 1'b0},  // R5 odd fail
    {7'h0C, 32'h0000_0003, 1'b1},  // R5 even ok
    {7'h0C, 32'h8000_0000, 1'b0},  // R5 even fail
    {7'h08, 32'h8000_0000, 1'b1},  // R4 parity off, bit32 data
    {7'h10, 32'h0000_0400, 1'b1},  // R6 match 00
    {7'h30, 32'h0000_0100, 1'b1},  // R6 bit9 match
    {7'h30, 32'h0000_0200, 1'b0},  // R6 mismatch
    {7'h50, 32'h0000_0200, 1'b1},  // R6 bit10 match
    {7'h20, 32'h0000_0200, 1'b1},  // R6 check off
    {7'h16, 32'h8000_005A, 1'b1},  // R3 R5 R6 combined pass
    {7'h16, 32'h0000_005A, 1'b0}   // R5 combined parity fail
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] i, input logic [7:0] d);
    @(negedge clk); idx = i; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] i, output logic [31:0] d);
    @(negedge clk); idx = i; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk); word = w; wvalid = 1'b1;
    @(negedge clk); wvalid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    host_rd(2'd1, d); check("R1 ctrl reset", d, 32'h0);
    host_rd(2'd2, d); check("R8 status reset", d, 32'h1);
    check("R2 rate reset", {31'b0, rate}, 32'h0);

    // R2 rate select
    host_wr(2'd1, 8'h01);
    check("R2 rate set", {31'b0, rate}, 32'h1);
    host_rd(2'd1, d); check("R1 ctrl readback", d, 32'h1);
    host_wr(2'd1, 8'h00);
    check("R2 rate clear", {31'b0, rate}, 32'h0);

    // R11 label load and readback order
    host_wr(2'd3, 8'h31);
    host_wr(2'd3, 8'h5A);
    host_wr(2'd3, 8'hC3);
    host_rd(2'd3, d); check("R11 label 0", d, 32'h31);
    host_rd(2'd3, d); check("R11 label 1", d, 32'h5A);
    host_rd(2'd3, d); check("R11 label 2", d, 32'hC3);

    // filter vectors
    for (int v = 0; v < NV; v++) begin
      logic [31:0] exp_d;
      host_wr(2'd1, {1'b0, VEC[v][39:33]});
      send(VEC[v][32:1]);
      exp_d = VEC[v][0] ? VEC[v][32:1] : 32'h0;
      host_rd(2'd0, d);
      check($sformatf("R3/R4/R5/R6 vector %0d", v), d, exp_d);
      host_rd(2'd2, d); check("R10 empty after vector", d, 32'h1);
    end

    // R7 table clear
    host_wr(2'd1, 8'h82);
    host_rd(2'd1, d); check("R7 ctrl bit7 reads 0", d, 32'h02);
    send(32'h0000_0031);
    host_rd(2'd0, d); check("R7 cleared table rejects", d, 32'h0);
    host_wr(2'd3, 8'h77);
    host_rd(2'd3, d); check("R7 pointer restarted", d, 32'h77);
    send(32'h0000_0077);
    host_rd(2'd0, d); check("R7 R3 reloaded label accepted", d, 32'h77);
    host_wr(2'd1, 8'h00);

    // FIFO fill, level, full, drop
    for (int k = 0; k < 15; k++) send(32'hA000_0000 + k);
    host_rd(2'd2, d); check("R8 below level", d, 32'h0);
    send(32'hA000_000F);
    host_rd(2'd2, d); check("R8 at level", d, 32'h2);
    for (int k = 16; k < 32; k++) send(32'hA000_0000 + k);
    host_rd(2'd2, d); check("R8 full", d, 32'h6);
    send(32'hBBBB_BBBB);
    host_rd(2'd2, d); check("R9 still full", d, 32'h6);
    host_wr(2'd2, 8'hFF);
    host_rd(2'd2, d); check("R8 status write ignored", d, 32'h6);
    for (int k = 0; k < 32; k++) begin
      host_rd(2'd0, d);
      check("R9 R10 pop order", d, 32'hA000_0000 + k);
    end
    host_rd(2'd0, d); check("R9 overflow word dropped", d, 32'h0);
    host_rd(2'd2, d); check("R10 empty", d, 32'h1);

    // data write ignored, empty read no side effect
    host_wr(2'd0, 8'h55);
    host_rd(2'd2, d); check("R8 data write ignored", d, 32'h1);
    host_rd(2'd0, d); check("R10 empty read zero", d, 32'h0);
    send(32'h0000_1234);
    host_rd(2'd0, d); check("R10 after empty read", d, 32'h0000_1234);
    // R12 hold
    repeat (3) @(negedge clk);
    check("R12 rdata holds", rdata, 32'h0000_1234);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule